// File: doc/BRIEF.md
# Reconfigurable Feed-Forward ALU Array

This block is a small grid of 8-bit processing elements: two columns and three rows. Data flows strictly downward, one row per clock. Each element picks its two operands from the outputs of the row above, using a routing choice made by configuration. It then applies one of a small set of integer operations, or forwards one operand unchanged. The first row draws its operands from two input ports, and one element of the last row drives the single output port. The array has no feedback path and no storage apart from one register stage per row. A valid flag moves through the rows alongside the data.

Configuration is loaded one bit per clock while a configuration-mode input is held high. The new settings sit in a shadow chain and take effect all at once on the first clock edge after the mode input falls. Any work still inside the array when loading starts is discarded. A caller loads a configuration for a computation, streams operand pairs through the array (one per cycle if wanted), and reconfigures between computations.

Top module: `ffa_array`

## Requirements
- R1: After reset the output valid is low and every element has opcode 0 with both selects 0, so an input pair (a, b) gives 8*a modulo 256 at the output.
- R2: Opcodes are 3 bits: 0 gives x+y mod 256, 1 gives x-y mod 256, 2 gives x AND y, 3 gives x OR y, 4 gives x XOR y, 5 gives x unchanged, and 6 and 7 give zero. Here x is the first operand and y the second.
- R3: Each operand select is a column index into the row above. For the first row, column 0 is the A input port and column 1 is the B input port.
- R4: Every row is registered. Inputs sampled at a rising edge appear at the output after the third rising edge, counting that one.
- R5: A result is flagged valid at the output only when its inputs were presented with the input valid high.
- R6: While configuration mode is high, each rising edge shifts the configuration bit into a 30-bit chain, and only the last 30 bits shifted count. The first of those 30 bits becomes bit 29. Element p = 2*row + column owns bits 5p+4..5p: opcode in 5p+2..5p, first-operand select in 5p+3, second-operand select in 5p+4.
- R7: The active configuration changes only on the first rising edge at which configuration mode is low after having been high. At that edge it takes the whole shadow chain at once.
- R8: At every edge where configuration mode is high, and at the commit edge, all valid flags are cleared and inputs are ignored. In-flight results are never delivered.
- R9: The output port carries column 0 of the last row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 1 | High while configuration bits are shifted in |
| cfg_bit | input | 1 | Serial configuration bit |
| in_valid | input | 1 | Operand pair on in_a/in_b is valid |
| in_a | input | 8 | First input operand stream |
| in_b | input | 8 | Second input operand stream |
| out_valid | output | 1 | Output result is valid |
| out_data | output | 8 | Result from the last row |

## Verification
The hardest case to reach from the ports is the discard of in-flight work at the moment configuration starts, together with the ignored inputs on the commit edge. In that situation the old and new settings meet inside the pipeline. The stimulus streams valid pairs back to back and raises configuration mode while they are still in the rows. It also keeps the input valid high through a whole load, including the commit edge, then shows that nothing emerges. A behavioural model in the bench tracks the shadow chain, the commit and the three valid stages, and is compared with the output on every clock. Some loads shift extra leading bits in, to show that only the last 30 count.

// File: rtl/ffa_pkg.sv
package ffa_pkg;
   localparam int OP_W = 3;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 3'd0,
      OP_SUB  = 3'd1,
      OP_AND  = 3'd2,
      OP_OR   = 3'd3,
      OP_XOR  = 3'd4,
      OP_PASS = 3'd5
   } op_e;
endpackage

// File: rtl/ffa_alu.sv
module ffa_alu
   import ffa_pkg::*;
#(
   parameter int W = 8
) (
   input  logic [OP_W-1:0] op,
   input  logic [W-1:0]    x,
   input  logic [W-1:0]    y,
   output logic [W-1:0]    res
);
   if (W < 1) begin : g_bad_w
      $error("ffa_alu: W must be at least 1");
   end

   always_comb begin
      case (op)
         OP_ADD:  res = x + y;
         OP_SUB:  res = x - y;
         OP_AND:  res = x & y;
         OP_OR:   res = x | y;
         OP_XOR:  res = x ^ y;
         OP_PASS: res = x;
         default: res = '0;
      endcase
   end
endmodule

// File: rtl/ffa_cfg.sv
module ffa_cfg #(
   parameter int NBITS = 30
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_mode,
   input  logic             cfg_bit,
   output logic [NBITS-1:0] active,
   output logic             flush
);
   logic [NBITS-1:0] shadow;
   logic             mode_q;
   logic             commit;

   if (NBITS < 2) begin : g_bad_n
      $error("ffa_cfg: NBITS must be at least 2");
   end

   assign commit = mode_q & ~cfg_mode;
   assign flush  = cfg_mode | commit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow <= '0;
         active <= '0;
         mode_q <= 1'b0;
      end else begin
         mode_q <= cfg_mode;
         if (cfg_mode) shadow <= {shadow[NBITS-2:0], cfg_bit};
         if (commit)   active <= shadow;
      end
   end

   // R7: configuration frozen while loading
   assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode |=> $stable(active));

   // R7: no change without a preceding load
   assert_cfg_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_mode && !mode_q) |=> $stable(active));
endmodule

// File: rtl/ffa_row.sv
module ffa_row
   import ffa_pkg::*;
#(
   parameter int W    = 8,
   parameter int COLS = 2,
   parameter int SELW = 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      flush,
   input  logic [COLS-1:0][W-1:0]    src,
   input  logic                      src_valid,
   input  logic [COLS*(OP_W+2*SELW)-1:0] cfg,
   output logic [COLS-1:0][W-1:0]    q,
   output logic                      q_valid
);
   localparam int PEW = OP_W + 2*SELW;

   if (COLS < 2 || (1 << SELW) < COLS) begin : g_bad_cols
      $error("ffa_row: select width too small for COLS");
   end

   function automatic logic [W-1:0] pick(input logic [COLS-1:0][W-1:0] s,
                                         input logic [SELW-1:0] sel);
      pick = (int'(sel) < COLS) ? s[sel] : '0;
   endfunction

   for (genvar c = 0; c < COLS; c++) begin : g_pe
      logic [OP_W-1:0] op;
      logic [SELW-1:0] sel_x, sel_y;
      logic [W-1:0]    opx, opy, res;

      assign op    = cfg[c*PEW +: OP_W];
      assign sel_x = cfg[c*PEW + OP_W +: SELW];
      assign sel_y = cfg[c*PEW + OP_W + SELW +: SELW];
      assign opx   = pick(src, sel_x);
      assign opy   = pick(src, sel_y);

      ffa_alu #(.W(W)) u_alu (.op(op), .x(opx), .y(opy), .res(res));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[c] <= '0;
         else        q[c] <= res;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_valid <= 1'b0;
      else        q_valid <= src_valid & ~flush;
   end

   // R8: a flush edge leaves the row empty
   assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush |=> !q_valid);

   // R5: valid only follows valid from the row above
   assert_valid_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      q_valid |-> $past(src_valid));
endmodule

// File: rtl/ffa_array.sv
module ffa_array
   import ffa_pkg::*;
#(
   parameter int W       = 8,
   parameter int COLS    = 2,
   parameter int ROWS    = 3,
   parameter int OUT_COL = 0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_mode,
   input  logic         cfg_bit,
   input  logic         in_valid,
   input  logic [W-1:0] in_a,
   input  logic [W-1:0] in_b,
   output logic         out_valid,
   output logic [W-1:0] out_data
);
   localparam int SELW  = (COLS > 1) ? $clog2(COLS) : 1;
   localparam int PEW   = OP_W + 2*SELW;
   localparam int ROWW  = COLS * PEW;
   localparam int NBITS = ROWS * ROWW;

   if (COLS < 2 || ROWS < 1 || OUT_COL < 0 || OUT_COL >= COLS || W < 1) begin : g_bad_par
      $error("ffa_array: illegal parameter combination");
   end

   logic [NBITS-1:0]                 cfg_act;
   logic                             flush;
   logic [ROWS:0][COLS-1:0][W-1:0]   sd;
   logic [ROWS:0]                    sv;

   ffa_cfg #(.NBITS(NBITS)) u_cfg (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bit(cfg_bit),
      .active(cfg_act), .flush(flush)
   );

   for (genvar c = 0; c < COLS; c++) begin : g_src
      if (c % 2 == 0) begin : g_a
         assign sd[0][c] = in_a;
      end else begin : g_b
         assign sd[0][c] = in_b;
      end
   end
   assign sv[0] = in_valid;

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      ffa_row #(.W(W), .COLS(COLS), .SELW(SELW)) u_row (
         .clk(clk), .rst_n(rst_n), .flush(flush),
         .src(sd[r]), .src_valid(sv[r]),
         .cfg(cfg_act[r*ROWW +: ROWW]),
         .q(sd[r+1]), .q_valid(sv[r+1])
      );
   end

   assign out_valid = sv[ROWS];
   assign out_data  = sd[ROWS][OUT_COL];

   // R8: loading stops delivery from the next edge on
   assert_out_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_mode |=> !out_valid);
endmodule

// File: tb/sim_ffa_array.sv
module sim_ffa_array;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_mode = 1'b0, cfg_bit = 1'b0, in_valid = 1'b0;
   logic [7:0] in_a = '0, in_b = '0;
   logic       out_valid;
   logic [7:0] out_data;

   int    checks = 0, errors = 0;
   string cur_req = "R1";

   always #5 clk = ~clk;

   ffa_array u0 (.clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_bit(cfg_bit),
                 .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
                 .out_valid(out_valid), .out_data(out_data));

   function automatic logic [7:0] alu_ref(int op, logic [7:0] x, logic [7:0] y);
      case (op)
         0: return x + y;
         1: return x - y;
         2: return x & y;
         3: return x | y;
         4: return x ^ y;
         5: return x;
         default: return 8'd0;
      endcase
   endfunction

   function automatic logic [7:0] eval(logic [29:0] cw, logic [7:0] a, logic [7:0] b);
      logic [7:0] prev [2];
      logic [7:0] cur [2];
      prev[0] = a; prev[1] = b;
      for (int r = 0; r < 3; r++) begin
         for (int c = 0; c < 2; c++) begin
            int p;
            p = r*2 + c;
            cur[c] = alu_ref(int'(cw[p*5 +: 3]), prev[cw[p*5+3]], prev[cw[p*5+4]]);
         end
         prev = cur;
      end
      return prev[0];
   endfunction

   function automatic logic [4:0] pe(int op, int sx, int sy);
      return {sy[0], sx[0], op[2:0]};
   endfunction

   // behavioural reference
   logic [29:0] m_shadow = '0, m_act = '0;
   logic        m_mode_q = 1'b0;
   logic [2:0]  pv = '0;
   logic [7:0]  pr [3];

   always @(posedge clk) begin
      if (!rst_n) begin
         m_shadow <= '0; m_act <= '0; m_mode_q <= 1'b0; pv <= '0;
      end else begin
         logic fl;
         fl = cfg_mode || (m_mode_q && !cfg_mode);
         pv[0] <= in_valid && !fl;
         pv[1] <= pv[0] && !fl;
         pv[2] <= pv[1] && !fl;
         pr[0] <= eval(m_act, in_a, in_b);
         pr[1] <= pr[0];
         pr[2] <= pr[1];
         if (cfg_mode) m_shadow <= {m_shadow[28:0], cfg_bit};
         if (m_mode_q && !cfg_mode) m_act <= m_shadow;
         m_mode_q <= cfg_mode;
      end
   end

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         check(cur_req, int'(out_valid), int'(pv[2]));
         if (out_valid && pv[2]) check(cur_req, int'(out_data), int'(pr[2]));
      end
   end

   task automatic load_cfg(logic [29:0] cw, int extra);
      cfg_mode = 1'b1;
      for (int i = 0; i < extra; i++) begin
         cfg_bit = 1'b1;
         @(negedge clk);
      end
      for (int i = 29; i >= 0; i--) begin
         cfg_bit = cw[i];
         @(negedge clk);
      end
      cfg_mode = 1'b0;
      cfg_bit  = 1'b0;
      @(negedge clk);
   endtask

   // send one pair and check output after exactly three edges
   task automatic one_shot(string req, logic [7:0] a, logic [7:0] b, logic [7:0] exp);
      in_valid = 1'b1; in_a = a; in_b = b;
      @(negedge clk);
      in_valid = 1'b0;
      check(req, int'(out_valid), 0);
      @(negedge clk);
      check(req, int'(out_valid), 0);
      @(negedge clk);
      check(req, int'(out_valid), 1);
      check(req, int'(out_data), int'(exp));
      @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [29:0] cfg_a, cfg_b, cfg_c;
      cfg_a = {pe(2,0,1), pe(3,0,1), pe(5,1,0), pe(4,0,1), pe(1,0,1), pe(0,0,1)};
      cfg_b = {pe(0,0,0), pe(4,1,0), pe(7,0,0), pe(0,0,1), pe(6,1,1), pe(2,0,1)};
      cfg_c = {pe(0,0,0), pe(5,0,0), pe(5,1,0), pe(1,0,1), pe(5,0,0), pe(5,1,0)};

      repeat (3) @(negedge clk);
      check("R1", int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", int'(out_valid), 0);

      cur_req = "R4";
      one_shot("R1 R4", 8'd3, 8'd77, 8'd24);
      one_shot("R1 R4 R9", 8'd40, 8'd1, 8'd64);

      cur_req = "R6";
      load_cfg(cfg_a, 2);
      one_shot("R6 R7", 8'd10, 8'd3, 8'd15);
      cur_req = "R2";
      one_shot("R2 wrap add", 8'd255, 8'd1, 8'd254);
      one_shot("R2 wrap sub", 8'd0, 8'd1, 8'd255);

      load_cfg(cfg_b, 0);
      one_shot("R2 R3 codes 6 7", 8'hF0, 8'h3C, 8'h30);

      cur_req = "R3";
      load_cfg(cfg_c, 0);
      one_shot("R3 port B", 8'd5, 8'd20, 8'd15);

      cur_req = "R5";
      for (int i = 0; i < 60; i++) begin
         in_valid = ($urandom_range(0, 3) != 0);
         in_a = 8'($urandom); in_b = 8'($urandom);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (4) @(negedge clk);

      cur_req = "R8";
      load_cfg(cfg_a, 0);
      in_valid = 1'b1; in_a = 8'd9; in_b = 8'd4;
      @(negedge clk);
      in_a = 8'd11;
      @(negedge clk);
      in_valid = 1'b0;
      cfg_mode = 1'b1;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R8 flush", int'(out_valid), 0);
      end
      cfg_mode = 1'b0;
      @(negedge clk);

      in_valid = 1'b1; in_a = 8'd1; in_b = 8'd2;
      cfg_mode = 1'b1;
      for (int i = 29; i >= 0; i--) begin
         cfg_bit = cfg_b[i];
         @(negedge clk);
      end
      cfg_mode = 1'b0;
      @(negedge clk);
      in_valid = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         check("R8 ignored", int'(out_valid), 0);
      end

      cur_req = "R7";
      for (int i = 0; i < 20; i++) begin
         in_valid = 1'b1; in_a = 8'($urandom); in_b = 8'($urandom);
         @(negedge clk);
      end
      in_valid = 1'b0;
      repeat (4) @(negedge clk);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule